// File: doc/BRIEF.md
# Exception Status and Cause Registers

This block holds the two exception-control registers of a small RISC system coprocessor. The Status register carries a five-level interrupt mask and a six-bit stack made of three mode/enable pairs: current, previous and old. The Cause register shows which interrupt levels are pending and the code of the most recent exception.

Taking an exception pushes the pair stack and drops the processor into kernel mode with interrupts off. A return-from-exception strobe pops the stack. The block combines the current enable bit, the mask and the pending levels into one take-interrupt output. Software reaches both registers through a single register read/write port. Redirecting the program counter, saving the return address and the pipeline itself are left to the surrounding core.

Top module: `exc_status_cause`

## Requirements
- R1: After reset, both registers read as zero, which means kernel mode with interrupts disabled, and `takeIrq` is 0.
- R2: A software write to Status (`regSel`=0) stores data bits [12:8] as the mask and bits [5:0] as the pair stack. Bit 0 is the current enable, bit 1 the current mode, bits 3:2 the previous pair and bits 5:4 the old pair. Every other Status bit reads as zero.
- R3: A software write to Cause (`regSel`=1) has no effect on any Cause bit.
- R4: Cause bits [12:8] show the level of `intReq` as it was sampled at the previous rising clock edge. Cause bits 31:13, 7 and 1:0 read as zero.
- R5: On `excEnter`, the stack shifts left by two and the current pair is cleared. The mask does not change.
- R6: On `excEnter`, `excCode` is loaded into Cause bits [6:2]. That field then holds its value until the next entry.
- R7: On `excReturn` without `excEnter`, the stack shifts right by two. The old pair is kept and is also copied into the previous pair. The exception code and the mask do not change.
- R8: `takeIrq` is 1 exactly when Status bit 0 is 1 and at least one bit is set in both the pending field and the mask field.
- R9: When strobes arrive in the same cycle, `excEnter` takes priority over `excReturn`. A software write to Status is dropped in any cycle that has either strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Software register write strobe |
| regSel | input | 1 | Register select: 0 = Status, 1 = Cause |
| regWrData | input | 32 | Software write data |
| regRdData | output | 32 | Combinational read of the selected register |
| intReq | input | 5 | Level-sensitive interrupt requests, one per level |
| excEnter | input | 1 | Exception entry strobe |
| excCode | input | 5 | Reason code captured on entry |
| excReturn | input | 1 | Return-from-exception strobe |
| takeIrq | output | 1 | Interrupt should be taken |

## Verification
Every register effect is due at the first rising edge after the stimulus: writes, stack pushes and pops, code capture and pending capture all land there. The read port and `takeIrq` are combinational from those registers, so they follow with no extra cycle. The bench drives inputs on the falling edge and updates its model at the next rising edge. It then reads both registers through the read port on the following falling edge. As a result, each check compares state exactly one edge after the stimulus.

// File: rtl/exc_sc_pkg.sv
package exc_sc_pkg;
  localparam int STACK_W  = 6;
  localparam int PAIR_W   = 2;
  localparam int MASK_LSB = 8;
  localparam int PEND_LSB = 8;
  localparam int CODE_LSB = 2;

  typedef struct packed {
    logic pushStack;
    logic popStack;
    logic wrStatus;
    logic loadCode;
  } exc_ctl_t;
endpackage

// File: rtl/exc_sc_ctrl.sv
module exc_sc_ctrl
  import exc_sc_pkg::*;
(
  input  logic     regWrEn,
  input  logic     regSel,
  input  logic     excEnter,
  input  logic     excReturn,
  output exc_ctl_t ctl
);
  // Entry wins over return; software writes yield to both strobes.
  always_comb begin
    ctl           = '0;
    ctl.pushStack = excEnter;
    ctl.loadCode  = excEnter;
    ctl.popStack  = excReturn && !excEnter;
    ctl.wrStatus  = regWrEn && !regSel && !excEnter && !excReturn;
  end
endmodule

// File: rtl/exc_sc_dp.sv
module exc_sc_dp
  import exc_sc_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int NUM_LEVELS = 5,
  parameter int CODE_W     = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  exc_ctl_t              ctl,
  input  logic [DATA_W-1:0]     wrData,
  input  logic                  rdSel,
  input  logic [NUM_LEVELS-1:0] intReq,
  input  logic [CODE_W-1:0]     codeIn,
  output logic [DATA_W-1:0]     statusVal,
  output logic [DATA_W-1:0]     causeVal,
  output logic [DATA_W-1:0]     rdData,
  output logic                  irqOut
);
  localparam int OLD_LSB = STACK_W - PAIR_W;

  logic [STACK_W-1:0]    stackQ, stackD;
  logic [NUM_LEVELS-1:0] maskQ, maskD;
  logic [NUM_LEVELS-1:0] pendQ;
  logic [NUM_LEVELS-1:0] hitVec;
  logic [CODE_W-1:0]     codeQ;

  always_comb begin
    stackD = stackQ;
    maskD  = maskQ;
    if (ctl.pushStack) begin
      stackD = {stackQ[STACK_W-PAIR_W-1:0], {PAIR_W{1'b0}}};
    end else if (ctl.popStack) begin
      stackD = {stackQ[STACK_W-1:OLD_LSB], stackQ[STACK_W-1:PAIR_W]};
    end else if (ctl.wrStatus) begin
      stackD = wrData[STACK_W-1:0];
      maskD  = wrData[MASK_LSB +: NUM_LEVELS];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stackQ <= '0;
      maskQ  <= '0;
      codeQ  <= '0;
    end else begin
      stackQ <= stackD;
      maskQ  <= maskD;
      if (ctl.loadCode) codeQ <= codeIn;
    end
  end

  // One pending flop and one qualified-hit term per interrupt level.
  for (genvar lvl = 0; lvl < NUM_LEVELS; lvl++) begin : g_level
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pendQ[lvl] <= 1'b0;
      else       pendQ[lvl] <= intReq[lvl];
    end
    assign hitVec[lvl] = pendQ[lvl] & maskQ[lvl];
  end

  always_comb begin
    statusVal                          = '0;
    statusVal[STACK_W-1:0]             = stackQ;
    statusVal[MASK_LSB +: NUM_LEVELS]  = maskQ;
    causeVal                           = '0;
    causeVal[PEND_LSB +: NUM_LEVELS]   = pendQ;
    causeVal[CODE_LSB +: CODE_W]       = codeQ;
  end

  assign rdData = rdSel ? causeVal : statusVal;
  assign irqOut = stackQ[0] & (|hitVec);
endmodule

// File: rtl/exc_status_cause.sv
module exc_status_cause
  import exc_sc_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int NUM_LEVELS = 5,
  parameter int CODE_W     = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic                  regSel,
  input  logic [DATA_W-1:0]     regWrData,
  output logic [DATA_W-1:0]     regRdData,
  input  logic [NUM_LEVELS-1:0] intReq,
  input  logic                  excEnter,
  input  logic [CODE_W-1:0]     excCode,
  input  logic                  excReturn,
  output logic                  takeIrq
);
  exc_ctl_t          ctl;
  logic [DATA_W-1:0] statusVal;
  logic [DATA_W-1:0] causeVal;

  exc_sc_ctrl u_ctrl (
    .regWrEn  (regWrEn),
    .regSel   (regSel),
    .excEnter (excEnter),
    .excReturn(excReturn),
    .ctl      (ctl)
  );

  exc_sc_dp #(
    .DATA_W    (DATA_W),
    .NUM_LEVELS(NUM_LEVELS),
    .CODE_W    (CODE_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .wrData   (regWrData),
    .rdSel    (regSel),
    .intReq   (intReq),
    .codeIn   (excCode),
    .statusVal(statusVal),
    .causeVal (causeVal),
    .rdData   (regRdData),
    .irqOut   (takeIrq)
  );
endmodule

// File: rtl/exc_sc_chk.sv
module exc_sc_chk
  import exc_sc_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int NUM_LEVELS = 5,
  parameter int CODE_W     = 5
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  regWrEn,
  input logic                  regSel,
  input logic [NUM_LEVELS-1:0] intReq,
  input logic                  excEnter,
  input logic [CODE_W-1:0]     excCode,
  input logic                  excReturn,
  input logic                  takeIrq,
  input logic [DATA_W-1:0]     statusVal,
  input logic [DATA_W-1:0]     causeVal
);
  AST_PUSH_STACK: assert property (@(posedge clk) disable iff (!rstN)
    excEnter |=> statusVal[STACK_W-1:0] == {$past(statusVal[STACK_W-3:0]), 2'b00}); // R5
  AST_PUSH_MASK: assert property (@(posedge clk) disable iff (!rstN)
    excEnter |=> $stable(statusVal[MASK_LSB +: NUM_LEVELS])); // R5
  AST_CODE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    excEnter |=> causeVal[CODE_LSB +: CODE_W] == $past(excCode)); // R6
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !excEnter |=> $stable(causeVal[CODE_LSB +: CODE_W])); // R6
  AST_POP_STACK: assert property (@(posedge clk) disable iff (!rstN)
    (excReturn && !excEnter) |=>
      statusVal[STACK_W-1:0] == {$past(statusVal[STACK_W-1:STACK_W-2]), $past(statusVal[STACK_W-1:2])}); // R7
  AST_PEND_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> causeVal[PEND_LSB +: NUM_LEVELS] == $past(intReq)); // R4
  AST_CAUSE_NO_SW: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regSel && !excEnter) |=> $stable(causeVal[CODE_LSB +: CODE_W])); // R3
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !statusVal[0] |-> !takeIrq); // R8
endmodule

bind exc_status_cause exc_sc_chk #(
  .DATA_W    (DATA_W),
  .NUM_LEVELS(NUM_LEVELS),
  .CODE_W    (CODE_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regWrEn  (regWrEn),
  .regSel   (regSel),
  .intReq   (intReq),
  .excEnter (excEnter),
  .excCode  (excCode),
  .excReturn(excReturn),
  .takeIrq  (takeIrq),
  .statusVal(statusVal),
  .causeVal (causeVal)
);

// File: tb/sim_exc_status_cause.sv
module sim_exc_status_cause;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regSel = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [4:0]  intReq = '0;
  logic        excEnter = 1'b0;
  logic [4:0]  excCode = '0;
  logic        excReturn = 1'b0;
  logic        takeIrq;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [5:0] mStack = '0;
  logic [4:0] mMask = '0;
  logic [4:0] mPend = '0;
  logic [4:0] mCode = '0;

  exc_status_cause u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData), .intReq(intReq),
    .excEnter(excEnter), .excCode(excCode), .excReturn(excReturn),
    .takeIrq(takeIrq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expStatus();
    return {19'd0, mMask, 2'b00, mStack};
  endfunction

  function automatic logic [31:0] expCause();
    return {19'd0, mPend, 1'b0, mCode, 2'b00};
  endfunction

  // Reads both registers through the port plus takeIrq.
  task automatic checkAll(input string req);
    regSel = 1'b0;
    #1 chk({req, " status"}, regRdData, expStatus());
    regSel = 1'b1;
    #1 chk({req, " cause"}, regRdData, expCause());
    chk({req, " takeIrq"}, {31'd0, takeIrq},
        {31'd0, mStack[0] & (|(mPend & mMask))});
  endtask

  // One clock: drive, update model at the edge (entry > return > write), settle.
  task automatic cyc(input logic wr, input logic sel, input logic [31:0] d,
                     input logic ent, input logic [4:0] code, input logic ret,
                     input logic [4:0] req);
    regWrEn = wr; regSel = sel; regWrData = d;
    excEnter = ent; excCode = code; excReturn = ret; intReq = req;
    @(posedge clk);
    mPend = req;
    if (ent) begin
      mStack = {mStack[3:0], 2'b00};
      mCode  = code;
    end else if (ret) begin
      mStack = {mStack[5:4], mStack[5:2]};
    end else if (wr && !sel) begin
      mStack = d[5:0];
      mMask  = d[12:8];
    end
    @(negedge clk);
    regWrEn = 1'b0; excEnter = 1'b0; excReturn = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checkAll("R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1 after reset");

    // R2: status write masks to the implemented fields
    cyc(1, 0, 32'hFFFF_FFFF, 0, 0, 0, 0);
    checkAll("R2 all ones");
    chk("R2 value", expStatus(), 32'h0000_1F3F);
    cyc(1, 0, 32'hA5A5_12C6, 0, 0, 0, 0);
    checkAll("R2 pattern");
    cyc(1, 0, 32'h0000_0000, 0, 0, 0, 0);
    checkAll("R2 clear");

    // R3: cause write ignored
    cyc(0, 0, 0, 1, 5'h15, 0, 5'h0A);
    cyc(1, 1, 32'hFFFF_FFFF, 0, 0, 0, 5'h0A);
    checkAll("R3 cause write ignored");
    cyc(1, 1, 32'h0000_0000, 0, 0, 0, 5'h0A);
    checkAll("R3 cause write zero ignored");

    // R5 / R6 / R7: full sweep of stack values through entry and returns
    for (int s = 0; s < 64; s++) begin
      cyc(1, 0, {19'd0, 5'(s * 7), 2'b11, 6'(s)}, 0, 0, 0, 0);
      checkAll("R2 sweep write");
      cyc(0, 0, 0, 1, 5'(s), 0, 0);
      checkAll("R5 R6 entry");
      cyc(0, 0, 0, 0, 5'(s + 3), 0, 0);
      checkAll("R6 code hold");
      cyc(0, 0, 0, 0, 0, 1, 0);
      checkAll("R7 return");
      cyc(0, 0, 0, 0, 0, 1, 0);
      checkAll("R7 second return");
    end

    // R4 / R8: sweep mask, requests and current enable
    for (int ie = 0; ie < 2; ie++) begin
      for (int m = 0; m < 32; m++) begin
        cyc(1, 0, {19'd0, 5'(m), 8'(ie)}, 0, 0, 0, 0);
        for (int r = 0; r < 32; r++) begin
          cyc(0, 0, 0, 0, 0, 0, 5'(r));
          checkAll("R4 R8 sweep");
        end
      end
    end

    // R9: simultaneous strobes
    cyc(1, 0, 32'h0000_1F2D, 0, 0, 0, 0);
    cyc(1, 0, 32'h0000_0F3F, 1, 5'h1C, 1, 0);
    checkAll("R9 entry beats return and write");
    cyc(1, 0, 32'h0000_003F, 0, 0, 1, 0);
    checkAll("R9 return beats write");
    cyc(1, 0, 32'h0000_0011, 0, 0, 0, 5'h1F);
    checkAll("R9 plain write afterwards");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule